// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block gathers a large set of interrupt request lines and reduces them to a small number of lines at a processor core. Inputs are organised in `NGRP` groups of `NSRC` sources each (twelve groups of eight by default, so 96 sources). Each source has an enable bit and a pending flag inside its group. When a group has a qualified source and its hold-off latch is clear, the group passes one request on to its own core line and then latches. It stays latched until software releases it by writing to the release register.

On the core side each line has a pending flag and an enable bit. A single global mask blocks every line. When the core takes an interrupt, the block reports a vector that names the winning group and source. In that same step it clears the winner's source flag and core flag and sets the global mask. Software reaches every register over a simple single-cycle register bus. Source flags accept plain writes, so an unused slot can serve as a software interrupt.

Top module: `grp_irq_expander`

## Requirements
- R1: After reset all enables, source flags, core flags and hold-off latches read 0, the global mask (address 0x23, bit 0) reads 1, and `core_req` is 0.
- R2: Register map: group g enable at 0x00+g, group g source flags at 0x10+g, core enables at 0x20, core flags at 0x21, hold-off latches at 0x22, global mask at 0x23. Bits above a register's width read 0. Unmapped addresses read 0 and ignore writes.
- R3: A rising edge on `src_irq[g*8+s]` sets source flag s of group g at the next clock edge. A level that stays high does not set the flag again after it has been cleared.
- R4: A group whose latch is clear and that has a source with both flag and enable set sets its core flag and its latch one clock edge later. A group with a set latch, or with no enabled pending source, forwards nothing.
- R5: `core_req` is 1 exactly when some core line has both flag and enable set and the global mask is 0. `core_vec[6:3]` carries the 0-based group index and `core_vec[2:0]` the 0-based source index of the winner.
- R6: The lowest-numbered group among the requesting lines wins. Within that group, the lowest-numbered source with flag and enable set wins.
- R7: A `core_take` pulse while `core_req` is 1 clears, at the next edge, the winning core flag and the winning source flag, and sets the global mask. A pulse while `core_req` is 0 does nothing.
- R8: Writing 1 to a bit of register 0x22 clears that group's latch. Writing 0 leaves it unchanged.
- R9: A write to a source flag register replaces all of its bits. A rising edge that arrives in the same cycle is lost. Writing 1 to a slot raises a software request through the normal path.
- R10: A write to 0x23 sets the global mask from `reg_wdata[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | 96 | Source request levels, group-major |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| core_take | input | 1 | Core accepts the presented interrupt |
| core_req | output | 1 | A serviceable interrupt is presented |
| core_vec | output | 7 | Group index [6:3], source index [2:0] |

## Verification
Register writes and the effects of `core_take` show at the first clock edge after the strobe. A source edge shows in its flag after one edge and in the core flag and latch after two. `core_req` and `core_vec` are combinational from the registered state, so they are valid in the same cycle as the state they describe. The bench drives every stimulus on a falling edge and waits the number of falling edges that matches each of these latencies before it reads. Reads of `reg_rdata` are taken a short delay after the address settles, halfway between rising edges.

// File: rtl/irqx_pkg.sv
// Shared sizes and register addresses for the grouped interrupt expander.
// Assumes group count fits the 4-bit group field of the register map.
package irqx_pkg;
    localparam int NGRP_DEF  = 12;
    localparam int NSRC_DEF  = 8;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;
    localparam logic [ADDR_W-1:0] A_EN_BASE  = 6'h00;
    localparam logic [ADDR_W-1:0] A_FLG_BASE = 6'h10;
    localparam logic [ADDR_W-1:0] A_CEN      = 6'h20;
    localparam logic [ADDR_W-1:0] A_CFLG     = 6'h21;
    localparam logic [ADDR_W-1:0] A_HOLD     = 6'h22;
    localparam logic [ADDR_W-1:0] A_GMSK     = 6'h23;
endpackage

// File: rtl/irqx_edge.sv
// Rising-edge detector for all source lines.
// Assumes the source levels are already synchronous to clk.
module irqx_edge #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irqx_grp.sv
// One source group: enable and flag registers, the hold-off latch and the
// in-group priority encoder (lowest index wins).
// Assumes at most one of flag write and edge set is meant per bit; a write wins.
module irqx_grp #(
    parameter int NSRC   = 8,
    parameter int SIDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   rise_i,
    input  logic              en_wr_i,
    input  logic              flg_wr_i,
    input  logic              hold_clr_i,
    input  logic [NSRC-1:0]   wdata_i,
    input  logic              take_i,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   flg_o,
    output logic              hold_o,
    output logic              fwd_o,
    output logic [SIDX_W-1:0] sidx_o
);
    logic [NSRC-1:0] qual;
    logic            hit;
    logic [NSRC-1:0] flg_nx;

    assign qual  = flg_o & en_o;
    assign hit   = |qual;
    assign fwd_o = hit & ~hold_o;

    // Pick the lowest-numbered qualified source.
    always_comb begin
        sidx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (qual[i]) sidx_o = SIDX_W'(i);
        end
    end

    // Next flag value: plain write or edge set, then clear of the taken source.
    always_comb begin
        flg_nx = flg_wr_i ? wdata_i : (flg_o | rise_i);
        if (take_i && hit) flg_nx[sidx_o] = 1'b0;
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= '0;
        else if (en_wr_i) en_o <= wdata_i;
    end

    // Source flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_o <= '0;
        else        flg_o <= flg_nx;
    end

    // Hold-off latch: set on forwarding, cleared by software release.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_o <= 1'b0;
        else if (hold_clr_i) hold_o <= 1'b0;
        else if (fwd_o)      hold_o <= 1'b1;
    end
endmodule

// File: rtl/irqx_core.sv
// Core-side stage: line flags and enables, global mask, line priority
// (lowest index wins) and acceptance of a take.
// Assumes take_i is a single-cycle pulse from the core.
module irqx_core #(
    parameter int NGRP   = 12,
    parameter int GIDX_W = $clog2(NGRP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NGRP-1:0]   fwd_i,
    input  logic              cen_wr_i,
    input  logic              cflg_wr_i,
    input  logic              msk_wr_i,
    input  logic [NGRP-1:0]   wdata_i,
    input  logic              msk_wdata_i,
    input  logic              take_i,
    output logic [NGRP-1:0]   cen_o,
    output logic [NGRP-1:0]   cflg_o,
    output logic              msk_o,
    output logic              req_o,
    output logic [GIDX_W-1:0] gidx_o,
    output logic [NGRP-1:0]   take_grp_o
);
    logic [NGRP-1:0] live;
    logic            accept;

    assign live   = cflg_o & cen_o;
    assign req_o  = (|live) & ~msk_o;
    assign accept = take_i & req_o;

    // Lowest-numbered live line wins.
    always_comb begin
        gidx_o = '0;
        for (int i = NGRP - 1; i >= 0; i--) begin
            if (live[i]) gidx_o = GIDX_W'(i);
        end
    end

    // One-hot of the group whose take is accepted this cycle.
    always_comb begin
        take_grp_o = '0;
        if (accept) take_grp_o[gidx_o] = 1'b1;
    end

    // Core enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)        cen_o <= '0;
        else if (cen_wr_i) cen_o <= wdata_i;
    end

    // Core flag register: write, then group forwarding, then take clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cflg_o <= '0;
        else        cflg_o <= ((cflg_wr_i ? wdata_i : cflg_o) | fwd_i) & ~take_grp_o;
    end

    // Global mask: set on an accepted take, otherwise software-written.
    always_ff @(posedge clk) begin
        if (!rst_n)        msk_o <= 1'b1;
        else if (accept)   msk_o <= 1'b1;
        else if (msk_wr_i) msk_o <= msk_wdata_i;
    end
endmodule

// File: rtl/grp_irq_expander.sv
// Top of the grouped interrupt expander: register decode and read mux,
// per-group units, the core stage and the vector output.
// Assumes a single-cycle write strobe and a combinational read.
module grp_irq_expander
    import irqx_pkg::*;
#(
    parameter int NGRP   = NGRP_DEF,
    parameter int NSRC   = NSRC_DEF,
    localparam int NSRCS  = NGRP * NSRC,
    localparam int GIDX_W = $clog2(NGRP),
    localparam int SIDX_W = $clog2(NSRC),
    localparam int VEC_W  = GIDX_W + SIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRCS-1:0]  src_irq,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              core_take,
    output logic              core_req,
    output logic [VEC_W-1:0]  core_vec
);
    logic [NSRCS-1:0]        rise;
    logic [NSRCS-1:0]        en_all;
    logic [NSRCS-1:0]        flg_all;
    logic [NGRP-1:0]         hold_vec;
    logic [NGRP-1:0]         fwd;
    logic [NGRP*SIDX_W-1:0]  sidx_all;
    logic [NGRP-1:0]         take_grp;
    logic [NGRP-1:0]         cen;
    logic [NGRP-1:0]         cflag;
    logic                    gmask;
    logic [GIDX_W-1:0]       gidx;
    logic                    hold_wr;

    assign hold_wr = reg_wr && (reg_addr == A_HOLD);

    irqx_edge #(.W(NSRCS)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (src_irq),
        .rise_o (rise)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] EN_A  = A_EN_BASE + ADDR_W'(g);
        localparam logic [ADDR_W-1:0] FLG_A = A_FLG_BASE + ADDR_W'(g);

        irqx_grp #(.NSRC(NSRC), .SIDX_W(SIDX_W)) grp_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .rise_i     (rise[g*NSRC +: NSRC]),
            .en_wr_i    (reg_wr && (reg_addr == EN_A)),
            .flg_wr_i   (reg_wr && (reg_addr == FLG_A)),
            .hold_clr_i (hold_wr && reg_wdata[g]),
            .wdata_i    (reg_wdata[NSRC-1:0]),
            .take_i     (take_grp[g]),
            .en_o       (en_all[g*NSRC +: NSRC]),
            .flg_o      (flg_all[g*NSRC +: NSRC]),
            .hold_o     (hold_vec[g]),
            .fwd_o      (fwd[g]),
            .sidx_o     (sidx_all[g*SIDX_W +: SIDX_W])
        );
    end

    irqx_core #(.NGRP(NGRP), .GIDX_W(GIDX_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fwd_i       (fwd),
        .cen_wr_i    (reg_wr && (reg_addr == A_CEN)),
        .cflg_wr_i   (reg_wr && (reg_addr == A_CFLG)),
        .msk_wr_i    (reg_wr && (reg_addr == A_GMSK)),
        .wdata_i     (reg_wdata[NGRP-1:0]),
        .msk_wdata_i (reg_wdata[0]),
        .take_i      (core_take),
        .cen_o       (cen),
        .cflg_o      (cflag),
        .msk_o       (gmask),
        .req_o       (core_req),
        .gidx_o      (gidx),
        .take_grp_o  (take_grp)
    );

    // Vector: winning line index above the in-group winner's index.
    assign core_vec = {gidx, sidx_all[gidx*SIDX_W +: SIDX_W]};

    // Read mux over the register map; unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (reg_addr == A_EN_BASE + ADDR_W'(g))
                reg_rdata[NSRC-1:0] = en_all[g*NSRC +: NSRC];
            if (reg_addr == A_FLG_BASE + ADDR_W'(g))
                reg_rdata[NSRC-1:0] = flg_all[g*NSRC +: NSRC];
        end
        case (reg_addr)
            A_CEN:   reg_rdata[NGRP-1:0] = cen;
            A_CFLG:  reg_rdata[NGRP-1:0] = cflag;
            A_HOLD:  reg_rdata[NGRP-1:0] = hold_vec;
            A_GMSK:  reg_rdata[0]        = gmask;
            default: ;
        endcase
    end
endmodule

// File: rtl/irqx_chk.sv
// Property checker for the grouped interrupt expander, bound to its top.
module irqx_chk #(
    parameter int NGRP   = 12,
    parameter int GIDX_W = 4,
    parameter int VEC_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_take,
    input logic             core_req,
    input logic [VEC_W-1:0] core_vec,
    input logic             gmask,
    input logic [NGRP-1:0]  cflag,
    input logic [NGRP-1:0]  hold_vec,
    input logic             hold_wr
);
    // R7
    take_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_take && core_req) |=> gmask);

    // R7
    take_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_take && core_req) |=> !cflag[$past(core_vec[VEC_W-1 -: GIDX_W])]);

    // R8
    hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hold_wr) |-> ((hold_vec & $past(hold_vec)) == $past(hold_vec)));

    // R5
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (int'(core_vec[VEC_W-1 -: GIDX_W]) < NGRP));

    // R5
    req_line_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> cflag[core_vec[VEC_W-1 -: GIDX_W]]);
endmodule

bind grp_irq_expander irqx_chk #(
    .NGRP(NGRP), .GIDX_W(GIDX_W), .VEC_W(VEC_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_take (core_take),
    .core_req  (core_req),
    .core_vec  (core_vec),
    .gmask     (gmask),
    .cflag     (cflag),
    .hold_vec  (hold_vec),
    .hold_wr   (hold_wr)
);

// File: tb/grp_irq_expander_tb_top.sv
// Self-checking bench: a register write/readback table, then directed tests.
module grp_irq_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_irq = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        core_take = 1'b0;
    logic        core_req;
    logic [6:0]  core_vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    grp_irq_expander dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .core_take (core_take),
        .core_req  (core_req),
        .core_vec  (core_vec)
    );

    // {addr, write data, expected readback}
    localparam logic [37:0] TBL [6] = '{
        {6'h00, 16'hFFFF, 16'h00FF},
        {6'h0B, 16'h00A5, 16'h00A5},
        {6'h20, 16'hFFFF, 16'h0FFF},
        {6'h20, 16'h0000, 16'h0000},
        {6'h0C, 16'h1234, 16'h0000},
        {6'h00, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic take();
        @(negedge clk);
        core_take = 1'b1;
        @(negedge clk);
        core_take = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(6'h23, v); check("R1 mask", v, 1);
        rd(6'h00, v); check("R1 enable", v, 0);
        rd(6'h21, v); check("R1 core flags", v, 0);
        rd(6'h22, v); check("R1 latches", v, 0);
        check("R1 core_req", int'(core_req), 0);

        // R2: register table walk
        for (int i = 0; i < 6; i++) begin
            wr(TBL[i][37:32], TBL[i][31:16]);
            rd(TBL[i][37:32], v);
            check("R2 readback", v, int'(TBL[i][15:0]));
        end
        wr(6'h0B, 16'h0000);

        // R3: edge on group 2 source 3 sets its flag one edge later
        @(negedge clk); src_irq[19] = 1'b1;
        @(negedge clk);
        rd(6'h12, v); check("R3 edge sets flag", v, 16'h08);
        @(negedge clk);
        rd(6'h21, v); check("R4 no enable no forward", v, 0);

        // R4: enabling forwards one edge later and sets the latch
        wr(6'h02, 16'h0008);
        @(negedge clk);
        rd(6'h21, v); check("R4 core flag", v, 16'h004);
        rd(6'h22, v); check("R4 latch", v, 16'h004);
        wr(6'h20, 16'h0004);
        check("R10 masked no req", int'(core_req), 0);
        wr(6'h23, 16'h0000);
        check("R5 req", int'(core_req), 1);
        check("R5 vector", int'(core_vec), 7'h13);

        // R6: lower source in same group wins
        @(negedge clk); src_irq[17] = 1'b1;
        @(negedge clk);
        wr(6'h02, 16'h000A);
        check("R6 source priority", int'(core_vec), 7'h11);

        // R7: take clears winner and sets mask
        take();
        rd(6'h21, v); check("R7 core flag cleared", v, 0);
        rd(6'h12, v); check("R7 source flag cleared", v, 16'h08);
        rd(6'h23, v); check("R7 mask set", v, 1);
        check("R7 req dropped", int'(core_req), 0);
        take();
        rd(6'h12, v); check("R7 take ignored without req", v, 16'h08);
        repeat (2) @(negedge clk);
        rd(6'h21, v); check("R4 held off", v, 0);

        // R8: latch release
        wr(6'h22, 16'h0000);
        rd(6'h22, v); check("R8 zero write ignored", v, 16'h004);
        wr(6'h22, 16'h0004);
        @(negedge clk);
        rd(6'h21, v); check("R8 released and forwarded", v, 16'h004);

        // R9/R6: software interrupt in group 0 wins over group 2
        wr(6'h00, 16'h0080);
        wr(6'h10, 16'h0080);
        wr(6'h20, 16'h0005);
        wr(6'h23, 16'h0000);
        check("R9 software request", int'(core_req), 1);
        check("R6 group priority", int'(core_vec), 7'h07);
        take();
        check("R7 mask blocks after take", int'(core_req), 0);
        rd(6'h10, v); check("R7 sw flag cleared", v, 0);
        wr(6'h23, 16'h0000);
        check("R10 unmask next winner", int'(core_vec), 7'h13);

        // R9: write in same cycle as an edge loses the edge
        @(negedge clk);
        src_irq[8] = 1'b1;
        reg_wr = 1'b1; reg_addr = 6'h11; reg_wdata = 16'h0000;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(6'h11, v); check("R9 edge lost to write", v, 0);
        src_irq[10] = 1'b1;
        @(negedge clk);
        rd(6'h11, v); check("R3 second edge", v, 16'h04);
        wr(6'h11, 16'h0001);
        rd(6'h11, v); check("R9 plain overwrite", v, 16'h01);
        repeat (2) @(negedge clk);
        rd(6'h11, v); check("R3 steady level no reset", v, 16'h01);

        done = 1'b1;
        finish_run();
    end
endmodule